// File: doc/BRIEF.md
# DMA Launch-on-Read Register Frontend

This block is the software-facing side of a DMA engine. Each of its register ports is a 32-bit memory-mapped slave with a private set of transfer parameters. The parameters are a 64-bit source address, a 64-bit destination address and a 64-bit byte count, a repetition count for two-dimensional copies, two 64-bit row strides and a packed configuration word. A core programs these registers on its own port. It then reads the launch register of the stream it wants. That read submits the assembled request to a single backend over a valid/ready handshake, and the read data is the transfer ID given to the request.

Each stream keeps its own ID counter and its own completion counter. The backend reports finished transfers in order with a one-cycle pulse tagged by stream, and each pulse advances that stream's completion ID by one. Software treats transfer `t` as finished once the completion ID of its stream has reached `t`. When several ports launch at once, a round-robin arbiter picks one port per handshake. Every other waiting port keeps its bus read stalled until its own request is accepted.

Each port runs a two-state machine. In `PS_IDLE` it serves ordinary accesses and acknowledges them in the same cycle. A read of a valid launch register takes the transition `T_LAUNCH` into `PS_WAIT`. The port raises its launch request there, and it leaves through `T_ACCEPT` in the cycle the backend takes the request, acknowledging the read with the ID. The arbiter has the states `ARB_FREE`, where it picks round-robin from a rotating pointer, and `ARB_HELD`. The transition `T_HOLD` locks a pick that the backend has not yet accepted. `T_RELEASE` frees the arbiter on the handshake and moves the pointer past the granted port.

Top module: `dma_launch_regs`

## Requirements
- R1: After reset every parameter register reads 0, the status register reads 0, every completion ID reads 0, and the first ID issued on any stream is 1.
- R2: Word offsets: source address low/high 0x00/0x04, destination low/high 0x08/0x0C, byte count low/high 0x10/0x14, configuration 0x18, repetitions 0x1C, source stride low/high 0x20/0x24, destination stride low/high 0x28/0x2C. All are read/write. The configuration register keeps bits 16:0 (bit 0 decouple_aw, bit 1 decouple_rw, bit 2 src_reduce_len, bit 3 dst_reduce_len, bits 6:4 src_max_llen, bits 9:7 dst_max_llen, bit 10 enable_nd, bits 13:11 src_protocol, bits 16:14 dst_protocol), and bits 31:17 read 0.
- R3: A read of the launch register at 0x40+4s (s below the stream count) presents that port's parameters on the backend interface with stream index s. The read returns the stream's current ID, zero-extended.
- R4: The launch read is not acknowledged until the backend handshake (valid and ready high together) accepts it. While valid is high and ready is low, the stream, ID and payload do not change.
- R5: Each accepted launch on stream s advances that stream's ID counter by one, wrapping at 2^ID_W. Other streams are not affected.
- R6: Each completion pulse on stream s advances the completion ID of s, readable at 0x80+4s, by one.
- R7: Bit s of the status register at 0x30 is 1 exactly when the last ID issued on stream s differs from the completion ID of s.
- R8: With several ports waiting at once, the port at or after the rotating pointer is granted first. After each handshake the pointer moves to the port after the granted one.
- R9: Writes to 0x30, to any launch or completion register, or to unmapped offsets change nothing. Reads of unmapped offsets return 0. A launch-register read for a stream at or above the stream count returns 0 at once and issues nothing.
- R10: Each port has its own parameter registers. A write on one port does not change what another port reads or launches.
- R11: Every access other than a valid launch read is acknowledged in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | NUM_PORTS | Per-port access request, held until acknowledged |
| reg_we | input | NUM_PORTS | Per-port write enable |
| reg_addr | input | NUM_PORTS*8 | Per-port byte offset |
| reg_wdata | input | NUM_PORTS*32 | Per-port write data |
| reg_ack | output | NUM_PORTS | Per-port access acknowledge |
| reg_rdata | output | NUM_PORTS*32 | Per-port read data, valid with acknowledge |
| bk_valid | output | 1 | Backend request valid |
| bk_ready | input | 1 | Backend accepts request |
| bk_stream | output | SW | Stream of the request |
| bk_id | output | ID_W | Transfer ID of the request |
| bk_src | output | 64 | Source address |
| bk_dst | output | 64 | Destination address |
| bk_len | output | 64 | Byte count |
| bk_conf | output | 17 | Configuration fields |
| bk_reps | output | 32 | Repetition count |
| bk_src_stride | output | 64 | Source row stride |
| bk_dst_stride | output | 64 | Destination row stride |
| cpl_valid | input | 1 | One-cycle completion pulse |
| cpl_stream | input | SW | Stream of the completion |

## Verification
The assertions assume that a bus master holds its request, address and write data steady until it sees the acknowledge, and drops the request in the cycle that follows. They also assume that completion pulses name a stream within range and never outnumber the launches on that stream. The bench drives every access through one task that follows this handshake. It issues completions only for transfers it has already launched. It changes backend ready only at a falling edge, so no handshake is cut in half.

// File: rtl/dma_launch_pkg.sv
package dma_launch_pkg;

    localparam int REG_AW  = 8;
    localparam int REG_DW  = 32;
    localparam int CONF_W  = 17;

    localparam logic [REG_AW-1:0] OFS_SRC_LO  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_SRC_HI  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_DST_LO  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_DST_HI  = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_LEN_LO  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_LEN_HI  = 8'h14;
    localparam logic [REG_AW-1:0] OFS_CONF    = 8'h18;
    localparam logic [REG_AW-1:0] OFS_REPS    = 8'h1C;
    localparam logic [REG_AW-1:0] OFS_SSTR_LO = 8'h20;
    localparam logic [REG_AW-1:0] OFS_SSTR_HI = 8'h24;
    localparam logic [REG_AW-1:0] OFS_DSTR_LO = 8'h28;
    localparam logic [REG_AW-1:0] OFS_DSTR_HI = 8'h2C;
    localparam logic [REG_AW-1:0] OFS_STATUS  = 8'h30;

    // address bits 7:6 select the per-stream windows
    localparam logic [1:0] WIN_LAUNCH = 2'b01;
    localparam logic [1:0] WIN_DONE   = 2'b10;

    typedef enum logic {
        PS_IDLE,
        PS_WAIT
    } port_state_e;

    typedef enum logic {
        ARB_FREE,
        ARB_HELD
    } arb_state_e;

endpackage

// File: rtl/dma_id_track.sv
module dma_id_track #(
    parameter int NS   = 4,
    parameter int ID_W = 32,
    parameter int SW   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [SW-1:0]        issue_stream,
    input  logic                 cpl_valid,
    input  logic [SW-1:0]        cpl_stream,
    output logic [NS*ID_W-1:0]   next_flat,
    output logic [NS*ID_W-1:0]   done_flat,
    output logic [NS-1:0]        busy
);

    logic [ID_W-1:0] nxt_q  [NS];
    logic [ID_W-1:0] done_q [NS];

    for (genvar gs = 0; gs < NS; gs++) begin : g_stream
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nxt_q[gs] <= ID_W'(1);
            end else if (issue && int'(issue_stream) == gs) begin
                nxt_q[gs] <= nxt_q[gs] + ID_W'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                done_q[gs] <= '0;
            end else if (cpl_valid && int'(cpl_stream) == gs) begin
                done_q[gs] <= done_q[gs] + ID_W'(1);
            end
        end

        assign next_flat[gs*ID_W +: ID_W] = nxt_q[gs];
        assign done_flat[gs*ID_W +: ID_W] = done_q[gs];
        assign busy[gs] = (nxt_q[gs] - ID_W'(1)) != done_q[gs];

        AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (issue && int'(issue_stream) == gs) |=> nxt_q[gs] == ID_W'($past(nxt_q[gs]) + ID_W'(1))); // R5

        AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (cpl_valid && int'(cpl_stream) == gs) |=> done_q[gs] == ID_W'($past(done_q[gs]) + ID_W'(1))); // R6

        AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy[gs]) |-> $past(cpl_valid && int'(cpl_stream) == gs)); // R7
    end

endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb
    import dma_launch_pkg::*;
#(
    parameter int N  = 2,
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  want,
    input  logic          ready,
    output logic          valid,
    output logic [IW-1:0] gidx,
    output logic [N-1:0]  gnt
);

    arb_state_e     state_q, state_d;
    logic [IW-1:0]  ptr_q, ptr_d;
    logic [IW-1:0]  held_q, held_d;
    logic [IW-1:0]  pick;
    logic           found;

    // rotating search starting at the pointer
    always_comb begin
        pick  = ptr_q;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(ptr_q) + k;
            if (j >= N) j = j - N;
            if (!found && want[j]) begin
                pick  = IW'(j);
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_FREE;
            ptr_q   <= '0;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        held_d  = held_q;
        valid   = 1'b0;
        gidx    = pick;
        unique case (state_q)
            ARB_FREE: begin
                valid = found;
                if (found && !ready) begin           // T_HOLD
                    state_d = ARB_HELD;
                    held_d  = pick;
                end else if (found) begin
                    ptr_d = (pick == IW'(N-1)) ? '0 : pick + IW'(1);
                end
            end
            ARB_HELD: begin
                valid = 1'b1;
                gidx  = held_q;
                if (ready) begin                     // T_RELEASE
                    state_d = ARB_FREE;
                    ptr_d   = (held_q == IW'(N-1)) ? '0 : held_q + IW'(1);
                end
            end
            default: state_d = ARB_FREE;
        endcase
    end

    always_comb begin
        gnt = '0;
        for (int k = 0; k < N; k++) begin
            if (valid && int'(gidx) == k) gnt[k] = 1'b1;
        end
    end

    AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && gidx == $past(gidx))); // R4

    AST_GRANT_WANTED: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> want[gidx]); // R8

endmodule

// File: rtl/dma_port_regs.sv
module dma_port_regs
    import dma_launch_pkg::*;
#(
    parameter int NS   = 4,
    parameter int ID_W = 32,
    parameter int SW   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 we,
    input  logic [REG_AW-1:0]    addr,
    input  logic [REG_DW-1:0]    wdata,
    output logic                 ack,
    output logic [REG_DW-1:0]    rdata,
    output logic                 launch_req,
    output logic [SW-1:0]        launch_stream,
    input  logic                 launch_done,
    input  logic [ID_W-1:0]      launch_id,
    input  logic [NS-1:0]        status,
    input  logic [NS*ID_W-1:0]   done_flat,
    output logic [63:0]          src,
    output logic [63:0]          dst,
    output logic [63:0]          len,
    output logic [CONF_W-1:0]    conf,
    output logic [31:0]          reps,
    output logic [63:0]          sstr,
    output logic [63:0]          dstr
);

    port_state_e    state_q, state_d;
    logic [SW-1:0]  stream_q, stream_d;
    logic [3:0]     sel;
    logic           sel_ok;
    logic           is_launch;
    logic           is_done;
    logic           wr_en;
    logic [REG_DW-1:0] rd_plain;

    assign sel       = addr[5:2];
    assign sel_ok    = int'(sel) < NS;
    assign is_launch = addr[7:6] == WIN_LAUNCH;
    assign is_done   = addr[7:6] == WIN_DONE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PS_IDLE;
            stream_q <= '0;
        end else begin
            state_q  <= state_d;
            stream_q <= stream_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        stream_d = stream_q;
        unique case (state_q)
            PS_IDLE: begin
                if (req && !we && is_launch && sel_ok) begin   // T_LAUNCH
                    state_d  = PS_WAIT;
                    stream_d = SW'(sel);
                end
            end
            PS_WAIT: begin
                if (launch_done) state_d = PS_IDLE;           // T_ACCEPT
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        ack        = 1'b0;
        rdata      = '0;
        launch_req = 1'b0;
        wr_en      = 1'b0;
        unique case (state_q)
            PS_IDLE: begin
                if (req && !(!we && is_launch && sel_ok)) begin
                    ack   = 1'b1;
                    wr_en = we;
                    rdata = we ? '0 : rd_plain;
                end
            end
            PS_WAIT: begin
                launch_req = 1'b1;
                if (launch_done) begin
                    ack   = 1'b1;
                    rdata = REG_DW'(launch_id);
                end
            end
            default: ;
        endcase
    end

    assign launch_stream = stream_q;

    always_comb begin
        rd_plain = '0;
        if (is_done) begin
            for (int s = 0; s < NS; s++) begin
                if (int'(sel) == s) rd_plain = REG_DW'(done_flat[s*ID_W +: ID_W]);
            end
        end else begin
            case (addr)
                OFS_SRC_LO:  rd_plain = src[31:0];
                OFS_SRC_HI:  rd_plain = src[63:32];
                OFS_DST_LO:  rd_plain = dst[31:0];
                OFS_DST_HI:  rd_plain = dst[63:32];
                OFS_LEN_LO:  rd_plain = len[31:0];
                OFS_LEN_HI:  rd_plain = len[63:32];
                OFS_CONF:    rd_plain = REG_DW'(conf);
                OFS_REPS:    rd_plain = reps;
                OFS_SSTR_LO: rd_plain = sstr[31:0];
                OFS_SSTR_HI: rd_plain = sstr[63:32];
                OFS_DSTR_LO: rd_plain = dstr[31:0];
                OFS_DSTR_HI: rd_plain = dstr[63:32];
                OFS_STATUS:  rd_plain = REG_DW'(status);
                default:     rd_plain = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src  <= '0;
            dst  <= '0;
            len  <= '0;
            conf <= '0;
            reps <= '0;
            sstr <= '0;
            dstr <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_SRC_LO:  src[31:0]   <= wdata;
                OFS_SRC_HI:  src[63:32]  <= wdata;
                OFS_DST_LO:  dst[31:0]   <= wdata;
                OFS_DST_HI:  dst[63:32]  <= wdata;
                OFS_LEN_LO:  len[31:0]   <= wdata;
                OFS_LEN_HI:  len[63:32]  <= wdata;
                OFS_CONF:    conf        <= wdata[CONF_W-1:0];
                OFS_REPS:    reps        <= wdata;
                OFS_SSTR_LO: sstr[31:0]  <= wdata;
                OFS_SSTR_HI: sstr[63:32] <= wdata;
                OFS_DSTR_LO: dstr[31:0]  <= wdata;
                OFS_DSTR_HI: dstr[63:32] <= wdata;
                default: ;
            endcase
        end
    end

    AST_WAIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_req && !launch_done) |=> (launch_req && $stable(launch_stream))); // R4

    AST_PARAMS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        launch_req |=> ($stable(src) && $stable(conf) && $stable(len))); // R4

endmodule

// File: rtl/dma_launch_regs.sv
module dma_launch_regs
    import dma_launch_pkg::*;
#(
    parameter int NUM_PORTS   = 2,
    parameter int NUM_STREAMS = 4,
    parameter int ID_W        = 32,
    localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        reg_req,
    input  logic [NUM_PORTS-1:0]        reg_we,
    input  logic [NUM_PORTS*8-1:0]      reg_addr,
    input  logic [NUM_PORTS*32-1:0]     reg_wdata,
    output logic [NUM_PORTS-1:0]        reg_ack,
    output logic [NUM_PORTS*32-1:0]     reg_rdata,
    output logic                        bk_valid,
    input  logic                        bk_ready,
    output logic [SW-1:0]               bk_stream,
    output logic [ID_W-1:0]             bk_id,
    output logic [63:0]                 bk_src,
    output logic [63:0]                 bk_dst,
    output logic [63:0]                 bk_len,
    output logic [16:0]                 bk_conf,
    output logic [31:0]                 bk_reps,
    output logic [63:0]                 bk_src_stride,
    output logic [63:0]                 bk_dst_stride,
    input  logic                        cpl_valid,
    input  logic [SW-1:0]               cpl_stream
);

    localparam int IW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic [NUM_PORTS-1:0]          want;
    logic [NUM_PORTS-1:0]          gnt;
    logic [IW-1:0]                 gidx;
    logic                          fire;
    logic [NUM_STREAMS*ID_W-1:0]   next_flat;
    logic [NUM_STREAMS*ID_W-1:0]   done_flat;
    logic [NUM_STREAMS-1:0]        busy;

    logic [SW-1:0]       p_stream [NUM_PORTS];
    logic [63:0]         p_src    [NUM_PORTS];
    logic [63:0]         p_dst    [NUM_PORTS];
    logic [63:0]         p_len    [NUM_PORTS];
    logic [CONF_W-1:0]   p_conf   [NUM_PORTS];
    logic [31:0]         p_reps   [NUM_PORTS];
    logic [63:0]         p_sstr   [NUM_PORTS];
    logic [63:0]         p_dstr   [NUM_PORTS];

    assign fire = bk_valid && bk_ready;

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        dma_port_regs #(
            .NS   (NUM_STREAMS),
            .ID_W (ID_W),
            .SW   (SW)
        ) u_port (
            .clk           (clk),
            .rst_n         (rst_n),
            .req           (reg_req[gp]),
            .we            (reg_we[gp]),
            .addr          (reg_addr[gp*8 +: 8]),
            .wdata         (reg_wdata[gp*32 +: 32]),
            .ack           (reg_ack[gp]),
            .rdata         (reg_rdata[gp*32 +: 32]),
            .launch_req    (want[gp]),
            .launch_stream (p_stream[gp]),
            .launch_done   (gnt[gp] && bk_ready),
            .launch_id     (bk_id),
            .status        (busy),
            .done_flat     (done_flat),
            .src           (p_src[gp]),
            .dst           (p_dst[gp]),
            .len           (p_len[gp]),
            .conf          (p_conf[gp]),
            .reps          (p_reps[gp]),
            .sstr          (p_sstr[gp]),
            .dstr          (p_dstr[gp])
        );
    end

    dma_rr_arb #(
        .N  (NUM_PORTS),
        .IW (IW)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (want),
        .ready (bk_ready),
        .valid (bk_valid),
        .gidx  (gidx),
        .gnt   (gnt)
    );

    dma_id_track #(
        .NS   (NUM_STREAMS),
        .ID_W (ID_W),
        .SW   (SW)
    ) u_ids (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue        (fire),
        .issue_stream (bk_stream),
        .cpl_valid    (cpl_valid),
        .cpl_stream   (cpl_stream),
        .next_flat    (next_flat),
        .done_flat    (done_flat),
        .busy         (busy)
    );

    always_comb begin
        bk_stream     = '0;
        bk_src        = '0;
        bk_dst        = '0;
        bk_len        = '0;
        bk_conf       = '0;
        bk_reps       = '0;
        bk_src_stride = '0;
        bk_dst_stride = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (int'(gidx) == p) begin
                bk_stream     = p_stream[p];
                bk_src        = p_src[p];
                bk_dst        = p_dst[p];
                bk_len        = p_len[p];
                bk_conf       = p_conf[p];
                bk_reps       = p_reps[p];
                bk_src_stride = p_sstr[p];
                bk_dst_stride = p_dstr[p];
            end
        end
    end

    always_comb begin
        bk_id = '0;
        for (int s = 0; s < NUM_STREAMS; s++) begin
            if (int'(bk_stream) == s) bk_id = next_flat[s*ID_W +: ID_W];
        end
    end

    AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_valid && !bk_ready) |=> ($stable(bk_id) && $stable(bk_stream) && $stable(bk_src)
                                     && $stable(bk_dst) && $stable(bk_len))); // R4

    AST_ACK_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire) |-> $onehot(reg_ack & want)); // R3

endmodule

// File: tb/dma_launch_regs_tb.sv
module dma_launch_regs_tb;

    localparam int NP   = 2;
    localparam int NS   = 2;
    localparam int IDW  = 4;
    localparam int MASK = (1 << IDW) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    reg_req = '0;
    logic [NP-1:0]    reg_we = '0;
    logic [NP*8-1:0]  reg_addr = '0;
    logic [NP*32-1:0] reg_wdata = '0;
    logic [NP-1:0]    reg_ack;
    logic [NP*32-1:0] reg_rdata;
    logic             bk_valid;
    logic             bk_ready = 1'b1;
    logic [0:0]       bk_stream;
    logic [IDW-1:0]   bk_id;
    logic [63:0]      bk_src, bk_dst, bk_len, bk_src_stride, bk_dst_stride;
    logic [16:0]      bk_conf;
    logic [31:0]      bk_reps;
    logic             cpl_valid = 1'b0;
    logic [0:0]       cpl_stream = '0;

    int n_chk = 0;
    int n_bad = 0;
    int hs_count = 0;
    int exp_next [NS];
    int exp_done [NS];
    bit finished = 0;
    logic [63:0] cap_src, cap_dst, cap_len, cap_sstr, cap_dstr;
    logic [16:0] cap_conf;
    logic [31:0] cap_reps;
    int cap_stream;

    always #2 clk = ~clk;

    dma_launch_regs #(.NUM_PORTS(NP), .NUM_STREAMS(NS), .ID_W(IDW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata), .bk_valid(bk_valid),
        .bk_ready(bk_ready), .bk_stream(bk_stream), .bk_id(bk_id), .bk_src(bk_src),
        .bk_dst(bk_dst), .bk_len(bk_len), .bk_conf(bk_conf), .bk_reps(bk_reps),
        .bk_src_stride(bk_src_stride), .bk_dst_stride(bk_dst_stride),
        .cpl_valid(cpl_valid), .cpl_stream(cpl_stream));

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // one access on port p; returns read data and cycles spent waiting for ack
    task automatic bus(input int p, input bit we, input logic [7:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int waits);
        @(negedge clk);
        reg_req[p] = 1'b1;
        reg_we[p]  = we;
        reg_addr[p*8 +: 8]    = a;
        reg_wdata[p*32 +: 32] = wd;
        waits = 0;
        #1;
        while (!reg_ack[p]) begin
            @(negedge clk);
            #1;
            waits++;
        end
        rd = reg_rdata[p*32 +: 32];
        @(negedge clk);
        reg_req[p] = 1'b0;
        reg_we[p]  = 1'b0;
    endtask

    task automatic wr(input int p, input logic [7:0] a, input logic [31:0] wd);
        logic [31:0] d;
        int w;
        bus(p, 1'b1, a, wd, d, w);
    endtask

    task automatic rdchk(input int p, input logic [7:0] a, input logic [31:0] exp, input string rq);
        logic [31:0] d;
        int w;
        bus(p, 1'b0, a, 32'h0, d, w);
        chk(rq, d, exp);
    endtask

    task automatic launch(input int p, input int s, output logic [31:0] id);
        int w;
        bus(p, 1'b0, 8'h40 + 8'(4*s), 32'h0, id, w);
    endtask

    task automatic complete(input int s);
        @(negedge clk);
        cpl_valid  = 1'b1;
        cpl_stream = 1'(s);
        @(negedge clk);
        cpl_valid  = 1'b0;
        exp_done[s] = (exp_done[s] + 1) & MASK;
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] v = '0;
        for (int s = 0; s < NS; s++)
            v[s] = (((exp_next[s] - 1) & MASK) != exp_done[s]);
        return v;
    endfunction

    // reference model: every accepted request is compared on its clock
    always begin
        @(negedge clk);
        #1;
        if (rst_n && bk_valid && bk_ready) begin
            chk("R5 issued id", 64'(bk_id), 64'(exp_next[bk_stream]));
            exp_next[bk_stream] = (exp_next[bk_stream] + 1) & MASK;
            hs_count++;
            cap_stream = int'(bk_stream);
            cap_src = bk_src; cap_dst = bk_dst; cap_len = bk_len; cap_conf = bk_conf;
            cap_reps = bk_reps; cap_sstr = bk_src_stride; cap_dstr = bk_dst_stride;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d0, d1;
        int w, hs0;
        for (int s = 0; s < NS; s++) begin exp_next[s] = 1; exp_done[s] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rdchk(0, 8'h00, 32'h0, "R1 src lo");
        rdchk(0, 8'h18, 32'h0, "R1 conf");
        rdchk(1, 8'h1C, 32'h0, "R1 reps");
        rdchk(0, 8'h30, 32'h0, "R1 status");
        rdchk(1, 8'h84, 32'h0, "R1 done1");

        // R11 same-cycle ack on ordinary read
        bus(0, 1'b0, 8'h00, 32'h0, d0, w);
        chk("R11 ack waits", 64'(w), 64'd0);

        // R2 register readback, conf keeps 17 bits
        for (int k = 0; k < 12; k++) wr(0, 8'(4*k), 32'hA000_0000 + 32'(k));
        for (int k = 0; k < 12; k++) begin
            if (k == 6)      rdchk(0, 8'(4*k), (32'hA000_0006) & 32'h1FFFF, "R2 conf");
            else             rdchk(0, 8'(4*k), 32'hA000_0000 + 32'(k), "R2 rw");
        end
        wr(0, 8'h18, 32'hFFFF_FFFF);
        rdchk(0, 8'h18, 32'h0001_FFFF, "R2 conf mask");

        // R3 launch on stream 0 with a programmed payload
        wr(0, 8'h00, 32'h3333_4444); wr(0, 8'h04, 32'h1111_2222);
        wr(0, 8'h08, 32'hC000_0000); wr(0, 8'h0C, 32'h0000_0001);
        wr(0, 8'h10, 32'd1024);      wr(0, 8'h14, 32'd0);
        wr(0, 8'h18, 32'h401);       wr(0, 8'h1C, 32'd4);
        wr(0, 8'h20, 32'd256);       wr(0, 8'h28, 32'd64);
        launch(0, 0, d0);
        chk("R3 returned id", 64'(d0), 64'd1);
        chk("R3 stream", 64'(cap_stream), 64'd0);
        chk("R3 src", cap_src, 64'h1111_2222_3333_4444);
        chk("R3 dst", cap_dst, 64'h1_C000_0000);
        chk("R3 len", cap_len, 64'd1024);
        chk("R3 conf", 64'(cap_conf), 64'h401);
        chk("R3 reps", 64'(cap_reps), 64'd4);
        chk("R3 strides", {cap_sstr[31:0], cap_dstr[31:0]}, {32'd256, 32'd64});

        // R10 port separation
        rdchk(1, 8'h00, 32'h0, "R10 other port untouched");
        wr(1, 8'h00, 32'h5555_6666);
        rdchk(0, 8'h00, 32'h3333_4444, "R10 own port kept");

        // R4 stall while backend not ready
        @(negedge clk) bk_ready = 1'b0;
        fork
            launch(0, 1, d0);
            begin
                repeat (4) @(negedge clk);
                #2;
                chk("R4 ack held low", 64'(reg_ack[0]), 64'd0);
                chk("R4 valid held", 64'(bk_valid), 64'd1);
                @(negedge clk) bk_ready = 1'b1;
            end
        join
        chk("R4 id after stall", 64'(d0), 64'd1);

        // R7 / R6 status and completions
        rdchk(1, 8'h30, exp_status(), "R7 both busy");
        complete(0);
        rdchk(0, 8'h80, 32'(exp_done[0]), "R6 done0");
        rdchk(0, 8'h30, exp_status(), "R7 stream0 idle");
        complete(1);
        rdchk(1, 8'h84, 32'd1, "R6 done1");
        rdchk(1, 8'h30, 32'h0, "R7 all idle");

        // R8 round robin: last grant was port 0, so port 1 wins first
        fork
            launch(0, 0, d0);
            launch(1, 0, d1);
        join
        chk("R8 port1 first", 64'(d1), 64'd2);
        chk("R8 port0 second", 64'(d0), 64'd3);
        launch(1, 0, d1);
        chk("R8 single", 64'(d1), 64'd4);
        fork
            launch(0, 0, d0);
            launch(1, 0, d1);
        join
        chk("R8 port0 first", 64'(d0), 64'd5);
        chk("R8 port1 second", 64'(d1), 64'd6);

        // R5 wrap of stream 1 counter; stream 0 untouched
        for (int k = 2; k <= 16; k++) begin
            launch(0, 1, d0);
            chk("R5 wrap seq", 64'(d0), 64'(k & MASK));
        end
        rdchk(0, 8'h30, exp_status(), "R7 busy after wrap");
        chk("R5 stream0 counter", 64'(exp_next[0]), 64'd7);

        // R9 ignored writes and unmapped reads
        wr(0, 8'h34, 32'hDEAD_BEEF);
        rdchk(0, 8'h34, 32'h0, "R9 unmapped");
        wr(0, 8'h80, 32'h0000_000F);
        rdchk(0, 8'h80, 32'(exp_done[0]), "R9 done not writable");
        wr(0, 8'h30, 32'h3);
        rdchk(0, 8'h30, exp_status(), "R9 status not writable");
        hs0 = hs_count;
        wr(1, 8'h40, 32'h1);
        bus(1, 1'b0, 8'h48, 32'h0, d1, w);
        chk("R9 out-of-range launch data", 64'(d1), 64'd0);
        chk("R9 out-of-range launch ack", 64'(w), 64'd0);
        repeat (2) @(negedge clk);
        chk("R9 no handshake", 64'(hs_count), 64'(hs0));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule